// File: doc/BRIEF.md
# Phase Accumulator Oscillator with Hard Sync

This block is the phase source of a voice generator. It holds a 24-bit running phase and, on every clock cycle, adds a frequency word to it. Software sets the frequency word through an 8-bit write port, one byte at a time. The low byte and the high byte each have their own register address. The frequency word is 16 bits wide and is zero-extended to the accumulator width, so the phase step lies between 0 and 65535 per cycle.

Two conditions force the phase back to zero. The first is a test control held high. The second is hard sync: the sync control is set and the most significant bit of a neighbouring source voice goes from low to high. The waveform logic downstream reads the top 12 phase bits. Bit 19 and the top bit are brought out on their own pins for neighbouring voices, which use them for sync and ring effects.

Top module: `phacc_osc`

## Requirements
- R1: While `rst_n` is low, the phase, the frequency word and the stored source history are all cleared, so every output reads zero.
- R2: On each clock edge that has no clear condition, the phase becomes the old phase plus the zero-extended 16-bit frequency word.
- R3: A write with `wr_addr_i` = 0 loads `wr_data_i` into frequency bits 7:0, and a write with `wr_addr_i` = 1 loads bits 15:8. Writes to any other address change nothing.
- R4: A frequency write takes effect in the addition on the clock edge after the edge that stores it.
- R5: The sum wraps modulo 2^24 and there is no carry-out.
- R6: When `test_i` is high at a clock edge, the phase becomes zero at that edge. This clear wins over the addition and over a frequency write in the same cycle.
- R7: When `sync_i` is high and `src_msb_i` is high at an edge after being low at the previous edge, the phase becomes zero. A source that stays high, or a source edge with `sync_i` low, does not clear the phase.
- R8: The stored source history follows `src_msb_i` on every edge, including edges where a clear happens.
- R9: `phase_o` is phase bits 23:12, `tap_o` is phase bit 19 and `msb_o` is phase bit 23.
- R10: After a clear, accumulation restarts from zero, so the first phase after the clear equals the frequency word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 = frequency low byte, 1 = frequency high byte |
| wr_data_i | input | 8 | Write data byte |
| test_i | input | 1 | Test control; holds the phase at zero |
| sync_i | input | 1 | Enables hard sync from the source voice |
| src_msb_i | input | 1 | Top phase bit of the source voice |
| phase_o | output | 12 | Top 12 phase bits, used for waveform generation |
| tap_o | output | 1 | Phase bit 19 |
| msb_o | output | 1 | Phase bit 23 |

## Verification
Assertions check every cycle that the phase is clear after reset, after a test cycle, and after a qualified sync edge. They also check that the first phase after a test clear stays within one 16-bit step of zero. Several behaviours can only be shown by the bench scenarios:
- the exact sum and its wrap over hundreds of cycles;
- byte-lane routing, and writes to unused addresses being ignored;
- the one-cycle latency of a frequency write;
- the source history being updated during a test clear, so that a source held high does not produce a second sync clear.

// File: rtl/phacc_pkg.sv
`timescale 1ns/1ps
package phacc_pkg;
    // Register offsets of the frequency byte lanes; the lane order matters
    localparam int FREQ_LO_OFS = 0;
    localparam int FREQ_HI_OFS = 1;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } freq_sel_e;
endpackage

// File: rtl/phacc_addr_dec.sv
`timescale 1ns/1ps
module phacc_addr_dec
    import phacc_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output freq_sel_e         sel_o
);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(FREQ_LO_OFS);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(FREQ_HI_OFS);

    always_comb begin
        sel_o = SEL_NONE;
        if (wr_en_i) begin
            if (wr_addr_i == LO_A)      sel_o = SEL_LO;
            else if (wr_addr_i == HI_A) sel_o = SEL_HI;
        end
    end
endmodule

// File: rtl/phacc_freq_reg.sv
`timescale 1ns/1ps
module phacc_freq_reg
    import phacc_pkg::*;
#(
    parameter int FREQ_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  freq_sel_e         sel_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [FREQ_W-1:0] freq_o
);
    localparam int LANES = FREQ_W / BYTE_W;

    logic [LANES-1:0]  lane_hit;
    logic [FREQ_W-1:0] freq_d, freq_q;

    // Lane 0 answers the low-byte select, lane 1 the high-byte select
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_hit[g] = (g == 0) ? (sel_i == SEL_LO) :
                             (g == 1) ? (sel_i == SEL_HI) : 1'b0;
    end

    always_comb begin
        freq_d = freq_q;
        for (int i = 0; i < LANES; i++) begin
            if (lane_hit[i]) freq_d[i*BYTE_W +: BYTE_W] = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) freq_q <= '0;
        else        freq_q <= freq_d;
    end

    assign freq_o = freq_q;
endmodule

// File: rtl/phacc_sync_det.sv
`timescale 1ns/1ps
module phacc_sync_det (
    input  logic clk,
    input  logic rst_n,
    input  logic test_i,
    input  logic sync_i,
    input  logic src_msb_i,
    output logic clr_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = src_msb_i;   // history follows the source on every edge
        clr_o  = test_i | (sync_i & src_msb_i & ~prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/phacc_osc.sv
`timescale 1ns/1ps
module phacc_osc
    import phacc_pkg::*;
#(
    parameter int ACC_W   = 24,
    parameter int FREQ_W  = 16,
    parameter int BYTE_W  = 8,
    parameter int PHASE_W = 12,
    parameter int TAP_BIT = 19,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [BYTE_W-1:0]  wr_data_i,
    input  logic               test_i,
    input  logic               sync_i,
    input  logic               src_msb_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               tap_o,
    output logic               msb_o
);
    localparam int PAD_W = ACC_W - FREQ_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } osc_st_t;

    freq_sel_e         sel;
    logic [FREQ_W-1:0] freq;
    logic              clr;
    logic [ACC_W-1:0]  addend;
    osc_st_t           st_d, st_q;

    phacc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .sel_o    (sel)
    );

    phacc_freq_reg #(.FREQ_W(FREQ_W), .BYTE_W(BYTE_W)) u_freq (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (sel),
        .data_i(wr_data_i),
        .freq_o(freq)
    );

    phacc_sync_det u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_i   (test_i),
        .sync_i   (sync_i),
        .src_msb_i(src_msb_i),
        .clr_o    (clr)
    );

    always_comb begin
        addend = {{PAD_W{1'b0}}, freq};
        st_d   = st_q;
        if (clr) st_d.acc = '0;
        else     st_d.acc = st_q.acc + addend;   // wraps modulo 2^ACC_W
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.acc[ACC_W-1 -: PHASE_W];
    assign tap_o   = st_q.acc[TAP_BIT];
    assign msb_o   = st_q.acc[ACC_W-1];
endmodule

// File: rtl/phacc_osc_chk.sv
`timescale 1ns/1ps
module phacc_osc_chk #(
    parameter int PHASE_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               test_i,
    input logic               sync_i,
    input logic               src_msb_i,
    input logic [PHASE_W-1:0] phase_o,
    input logic               tap_o,
    input logic               msb_o
);
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (phase_o == '0 && !tap_o && !msb_o));

    a_r6_test_clears: assert property (@(posedge clk) disable iff (!rst_n)
        test_i |=> (phase_o == '0 && !tap_o && !msb_o));

    a_r7_sync_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && src_msb_i && !$past(src_msb_i) && $past(rst_n))
        |=> (phase_o == '0 && !tap_o && !msb_o));

    // R10: one step after a test clear the phase is at most one 16-bit step
    a_r10_restart_small: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_i && $past(test_i) && $past(rst_n))
        |=> (phase_o[PHASE_W-1:4] == '0 && !msb_o));
endmodule

bind phacc_osc phacc_osc_chk #(.PHASE_W(PHASE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_i   (test_i),
    .sync_i   (sync_i),
    .src_msb_i(src_msb_i),
    .phase_o  (phase_o),
    .tap_o    (tap_o),
    .msb_o    (msb_o)
);

// File: tb/phacc_osc_bench.sv
`timescale 1ns/1ps
module phacc_osc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        test = 1'b0;
    logic        sync = 1'b0;
    logic        src = 1'b0;
    logic [11:0] phase;
    logic        tap;
    logic        msb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [23:0] exp_q[$];
    string       tag_q[$];

    logic [23:0] m_acc  = '0;
    logic [15:0] m_freq = '0;
    logic        m_prev = 1'b0;

    always #2.5 clk = ~clk;

    phacc_osc u_phacc_osc (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .test_i(test), .sync_i(sync), .src_msb_i(src),
        .phase_o(phase), .tap_o(tap), .msb_o(msb)
    );

    // Driver: drive one cycle of stimulus and push the expected phase
    task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                        input logic t, input logic s, input logic m, input string tag);
        logic clr;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; test = t; sync = s; src = m;
        clr = t | (s & m & ~m_prev);
        m_acc = clr ? 24'h0 : m_acc + {8'h00, m_freq};
        if (we && a == 2'd0) m_freq[7:0]  = d;
        if (we && a == 2'd1) m_freq[15:8] = d;
        m_prev = m;
        exp_q.push_back(m_acc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, src, tag);
    endtask

    // Monitor: pops and compares after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [23:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (phase !== e[23:12]) begin
                fails++;
                $display("FAIL %s phase actual=%h expected=%h", t, phase, e[23:12]);
            end
            checks++;
            if (tap !== e[19] || msb !== e[23]) begin
                fails++;
                $display("FAIL R9 tap/msb actual=%b%b expected=%b%b", tap, msb, e[19], e[23]);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (phase !== 12'h0 || tap !== 1'b0 || msb !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual=%h%b%b expected=000_0_0", phase, tap, msb);
        end
        rst_n = 1'b1;

        // R3/R4: load 0x1000 byte by byte
        step(1'b1, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R3 low byte");
        step(1'b1, 2'd1, 8'h10, 1'b0, 1'b0, 1'b0, "R4 high byte latency");
        idle(8, "R2 accumulate");
        // R3: unused addresses ignored
        step(1'b1, 2'd2, 8'hFF, 1'b0, 1'b0, 1'b0, "R3 addr2 ignored");
        step(1'b1, 2'd3, 8'hFF, 1'b0, 1'b0, 1'b0, "R3 addr3 ignored");
        idle(4, "R3 after ignored writes");
        // R6 then R10
        step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, "R6 test clear");
        idle(3, "R10 restart");
        // R5: max step, run past wrap
        step(1'b1, 2'd0, 8'hFF, 1'b0, 1'b0, 1'b0, "R3 low FF");
        step(1'b1, 2'd1, 8'hFF, 1'b0, 1'b0, 1'b0, "R3 high FF");
        idle(300, "R5 wrap");
        // R7 sync
        step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, "R7 src low");
        step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, "R7 sync edge clear");
        step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, "R7 src held high");
        step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, "R7 src falls");
        step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, "R7 edge without sync");
        idle(2, "R7 after");
        // R8: history updated while test clears
        step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R8 src low");
        step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, "R8 edge under test");
        step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, "R8 no second clear");
        idle(3, "R8 after");
        // R6 priority over a write in the same cycle, R4 latency of that write
        step(1'b1, 2'd1, 8'h02, 1'b1, 1'b0, 1'b0, "R6 clear with write");
        idle(4, "R4 new word after clear");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule